// File: doc/BRIEF.md
# Soft-Mute Digital Volume Attenuator

This block is a per-channel digital volume stage for a multichannel audio path. Each channel takes a signed two's-complement sample and multiplies it by a gain chosen with an 8-bit attenuation code. The gain ladder runs from 0 dB down to -63.5 dB in 0.5 dB steps, and beyond its last step lies full attenuation, which produces a zero output. All channels share one sample-valid strobe. Every channel has its own code, its own soft-mute request and its own disable input.

Each channel keeps its applied level in a ramp register that is separate from the programmed code. The ramp register moves at most one 0.5 dB step per accepted sample. When soft mute is requested, the level walks down the ladder to full attenuation. When mute is released, or when the programmed code changes, the level walks toward the new target in the same way. This stepping is what keeps level changes free of clicks. A disabled channel outputs the mid-scale zero code, and its ramp keeps running underneath.

Top module: `soft_mute_atten`

## Requirements
- R1: After reset, out_valid is 0, out_data is all zeros and every channel's applied level is 0 dB. A sample sent at code 0xFF (the reset default) therefore comes out unchanged.
- R2: A code c in 128..255 targets an attenuation of s = 255 - c half-dB steps (s = 0..127). Any code in 0..127 targets full attenuation (s = 128), and a channel at full attenuation outputs 0.
- R3: For an applied step count s below 128, let oct = s / 12 and f = s % 12. The output is floor((x*M[f] + 2^(15+oct)) / 2^(16+oct)), saturated to the signed sample range. M = {65536, 61870, 58409, 55142, 52057, 49145, 46396, 43801, 41350, 39037, 36854, 34792}.
- R4: Every input sample is scaled with the level that applies before the sample is accepted. On each accepted sample, the applied level then moves one step toward its target, or stays put if it has already reached the target.
- R5: While mute is requested, the target is full attenuation, so the level ramps one step per sample down to s = 128. After mute is released, the level ramps back one step per sample to the step count the code selects.
- R6: A channel whose disable input is 1 outputs 0 for every sample. Its ramp still advances, so after the channel is re-enabled the output uses the level the ramp has reached by then.
- R7: out_valid is high exactly one cycle after each cycle with in_valid high, and low otherwise. out_data changes only together with out_valid.
- R8: Channels are independent. Each channel's code, mute and disable inputs affect only that channel's output slice. Channel k occupies bits [24k+23:24k].
- R9: While in_valid is low, no channel's applied level moves, however long the gap lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe shared by all channels |
| in_data | input | NUM_CH*DATA_W | Signed input samples, channel k at slice k |
| att_code | input | NUM_CH*CODE_W | Attenuation code per channel |
| mute_req | input | NUM_CH | Soft-mute request per channel |
| ch_disable | input | NUM_CH | Forces the channel's output to zero |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | NUM_CH*DATA_W | Scaled signed samples |

## Verification
The bench builds the block at its defaults: two channels, 24-bit samples and 8-bit codes. With these values the complete 128-step ladder and all eleven octave shifts can be reached, including the final partial octave and the step into full mute. Two channels let the bench ramp one channel through mute, disable and code changes while the other stays fixed, which exercises channel independence. The 24-bit width puts both sample extremes and the rounding boundary of every shift into the stimulus.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int FRAC_W        = 16;
    localparam int STEPS_PER_OCT = 12;

    // 0.5 dB fractional multipliers for one 6 dB octave, Q16
    function automatic logic [FRAC_W:0] frac_mult(input logic [3:0] idx);
        case (idx)
            4'd0:    frac_mult = 17'd65536;
            4'd1:    frac_mult = 17'd61870;
            4'd2:    frac_mult = 17'd58409;
            4'd3:    frac_mult = 17'd55142;
            4'd4:    frac_mult = 17'd52057;
            4'd5:    frac_mult = 17'd49145;
            4'd6:    frac_mult = 17'd46396;
            4'd7:    frac_mult = 17'd43801;
            4'd8:    frac_mult = 17'd41350;
            4'd9:    frac_mult = 17'd39037;
            4'd10:   frac_mult = 17'd36854;
            4'd11:   frac_mult = 17'd34792;
            default: frac_mult = 17'd0;
        endcase
    endfunction
endpackage

// File: rtl/atten_level_ctrl.sv
module atten_level_ctrl #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] code,
    input  logic              mute,
    output logic [CODE_W-1:0] att
);
    localparam logic [CODE_W-1:0] FULL = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [CODE_W-1:0] att;
    } lvl_t;

    lvl_t lvl_d, lvl_q;
    logic [CODE_W-1:0] target;

    always_comb begin
        lvl_d = lvl_q;
        if (mute || !code[CODE_W-1]) begin
            target = FULL;
        end else begin
            target = ~code;
        end
        if (in_valid) begin
            if (lvl_q.att < target) begin
                lvl_d.att = lvl_q.att + 1'b1;
            end else if (lvl_q.att > target) begin
                lvl_d.att = lvl_q.att - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign att = lvl_q.att;

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (att == $past(att)) || (att == $past(att) + 1'b1) || (att == $past(att) - 1'b1));
    // R9
    hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(att));
    // R2
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        att <= FULL);
    // R5
    mute_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute && att != FULL) |=> att == $past(att) + 1'b1);
endmodule

// File: rtl/atten_gain_mul.sv
module atten_gain_mul
    import atten_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int STEP_W = 8
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [STEP_W-1:0] steps,
    output logic [DATA_W-1:0] result
);
    localparam int PROD_W = DATA_W + FRAC_W + 2;
    localparam logic [STEP_W-1:0] FULL = STEP_W'(1) << (STEP_W - 1);
    localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] MINV = -PROD_W'(64'sd1 <<< (DATA_W - 1));

    logic [STEP_W-1:0]        oct;
    logic [3:0]               frac;
    logic [7:0]               sh;
    logic signed [PROD_W-1:0] prod, half, rounded, shifted;

    always_comb begin
        oct     = steps / STEP_W'(STEPS_PER_OCT);
        frac    = 4'(steps % STEP_W'(STEPS_PER_OCT));
        sh      = 8'(FRAC_W) + 8'(oct);
        prod    = PROD_W'($signed(sample)) * PROD_W'($signed({1'b0, frac_mult(frac)}));
        half    = PROD_W'(1) << (sh - 8'd1);
        rounded = prod + half;
        shifted = rounded >>> sh;
        if (steps >= FULL) begin
            result = '0;
        end else if (shifted > MAXV) begin
            result = MAXV[DATA_W-1:0];
        end else if (shifted < MINV) begin
            result = MINV[DATA_W-1:0];
        end else begin
            result = shifted[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/soft_mute_atten.sv
module soft_mute_atten #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 24,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NUM_CH*DATA_W-1:0] in_data,
    input  logic [NUM_CH*CODE_W-1:0] att_code,
    input  logic [NUM_CH-1:0]        mute_req,
    input  logic [NUM_CH-1:0]        ch_disable,
    output logic                     out_valid,
    output logic [NUM_CH*DATA_W-1:0] out_data
);
    typedef struct packed {
        logic                     vld;
        logic [NUM_CH*DATA_W-1:0] data;
    } out_t;

    out_t out_d, out_q;
    logic [DATA_W-1:0] scaled [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CODE_W-1:0] att;

        atten_level_ctrl #(.CODE_W(CODE_W)) u_lvl (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .code     (att_code[ch*CODE_W +: CODE_W]),
            .mute     (mute_req[ch]),
            .att      (att)
        );

        atten_gain_mul #(.DATA_W(DATA_W), .STEP_W(CODE_W)) u_mul (
            .sample (in_data[ch*DATA_W +: DATA_W]),
            .steps  (att),
            .result (scaled[ch])
        );

        // R6
        dis_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && ch_disable[ch]) |=> out_data[ch*DATA_W +: DATA_W] == '0);
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = in_valid;
        if (in_valid) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                out_d.data[ch*DATA_W +: DATA_W] = ch_disable[ch] ? '0 : scaled[ch];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_data  = out_q.data;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: tb/tb_soft_mute_atten.sv
`timescale 1ns/1ps
module tb_soft_mute_atten;
    localparam int NUM_CH = 2;
    localparam int DW     = 24;
    localparam int CW     = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [NUM_CH*DW-1:0] in_data = '0;
    logic [NUM_CH*CW-1:0] att_code = {8'hFF, 8'hFF};
    logic [NUM_CH-1:0]    mute_req = '0;
    logic [NUM_CH-1:0]    ch_disable = '0;
    logic                 out_valid;
    logic [NUM_CH*DW-1:0] out_data;

    always #2.5 clk = ~clk;

    soft_mute_atten #(.NUM_CH(NUM_CH), .DATA_W(DW), .CODE_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .att_code(att_code), .mute_req(mute_req), .ch_disable(ch_disable),
        .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct {
        logic [NUM_CH*DW-1:0] data;
        string                tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    m_att [NUM_CH];
    bit    done = 0;
    logic [31:0] seed = 32'h1234_5678;

    int tbl [12] = '{65536, 61870, 58409, 55142, 52057, 49145,
                     46396, 43801, 41350, 39037, 36854, 34792};

    function automatic int tgt(input logic [7:0] c, input logic m);
        if (m || c < 8'd128) return 128;
        return 255 - int'(c);
    endfunction

    function automatic logic [DW-1:0] model_gain(input logic [DW-1:0] x, input int s);
        longint p, r;
        int sh;
        if (s >= 128) return '0;
        sh = 16 + s / 12;
        p  = longint'($signed(x)) * longint'(tbl[s % 12]);
        r  = (p + (64'sd1 <<< (sh - 1))) >>> sh;
        if (r > 64'sd8388607) r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return r[DW-1:0];
    endfunction

    task automatic send(input logic [DW-1:0] s0, input logic [DW-1:0] s1, input string tag);
        item_t it;
        @(negedge clk);
        in_data  = {s1, s0};
        in_valid = 1'b1;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            logic [DW-1:0] xs;
            int t;
            xs = ch == 0 ? s0 : s1;
            it.data[ch*DW +: DW] = ch_disable[ch] ? '0 : model_gain(xs, m_att[ch]);
            t = tgt(att_code[ch*CW +: CW], mute_req[ch]);
            if (m_att[ch] < t) m_att[ch]++;
            else if (m_att[ch] > t) m_att[ch]--;
        end
        it.tag = tag;
        q.push_back(it);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[31:8];
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R7: unexpected out_valid, actual data %h expected none", out_data);
            end else begin
                item_t it;
                it = q.pop_front();
                if (out_data !== it.data) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, out_data, it.data);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int ch = 0; ch < NUM_CH; ch++) m_att[ch] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1: actual valid %b data %h expected 0 0", out_valid, out_data);
        end
        // R1 0 dB pass-through at default code
        send(24'h123456, 24'hFEDCBA, "R1");
        send(24'h7FFFFF, 24'h800000, "R1");
        // R4 ramp toward a new code
        att_code = {8'hFF, 8'hE6};
        for (int i = 0; i < 30; i++) send(rnd(), rnd(), "R4");
        // R3 various levels and extremes
        att_code = {8'hC8, 8'h80};
        for (int i = 0; i < 70; i++) send(rnd(), rnd(), "R3");
        send(24'h7FFFFF, 24'h800000, "R3");
        send(24'h000001, 24'hFFFFFF, "R3");
        send(24'h008000, 24'hFF8000, "R3");
        att_code = {8'hFF, 8'hFF};
        for (int i = 0; i < 130; i++) send(rnd(), rnd(), "R4");
        // R5 mute ramp on ch0, ch1 untouched (R8)
        att_code = {8'hF0, 8'hFF};
        mute_req = 2'b01;
        for (int i = 0; i < 140; i++) send(rnd(), rnd(), "R5");
        send(24'h7FFFFF, 24'h7FFFFF, "R8");
        // R5 release and ramp back
        mute_req = 2'b00;
        for (int i = 0; i < 140; i++) send(rnd(), rnd(), "R5");
        // R6 disable ch1 while its level ramps, then re-enable
        att_code = {8'hA0, 8'hFF};
        ch_disable = 2'b10;
        for (int i = 0; i < 40; i++) send(rnd(), rnd(), "R6");
        ch_disable = 2'b00;
        for (int i = 0; i < 20; i++) send(rnd(), rnd(), "R6");
        // R2 low codes mean full attenuation
        att_code = {8'h32, 8'h7F};
        for (int i = 0; i < 140; i++) send(rnd(), rnd(), "R2");
        // R9 long idle gap, then level unchanged from model
        att_code = {8'hFF, 8'hFF};
        send(rnd(), rnd(), "R9");
        repeat (50) @(negedge clk);
        send(24'h400000, 24'hC00000, "R9");
        repeat (50) @(negedge clk);
        send(24'h400000, 24'hC00000, "R9");
        repeat (5) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R7: actual %0d pending results expected 0", q.size());
        end
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule